// File: doc/BRIEF.md
# I2C Interrupt Vector and Status Unit

This unit collects the event pulses that an I2C bus engine produces and turns them into three software-visible registers: a status register of sticky event flags, a mask register that enables individual sources onto one interrupt line, and a vector register. Reading the vector register returns a small code that names the enabled pending source with the highest priority. Software reads that one register instead of scanning the status bits.

There are seven event sources. Each arrives as a single-cycle pulse: arbitration lost, no-acknowledge, register-access ready, receive data ready, transmit data ready, stop detected and addressed as slave. Two further status bits are not sticky flags. One shows the receive-full level from the engine. The other is a bus-busy bit that a START sets and a STOP clears. The register port is 16 bits wide and uses byte offsets. Register reads are combinational from the current address. Writes, read side effects and event captures take effect at the next rising clock edge.

Top module: `i2c_event_vector`

## Requirements
- R1: After reset the mask, the seven event flags and the bus-busy bit are all 0, `irq` is low, and the mask, status and vector registers all read 0.
- R2: An event pulse sets its status flag whatever the mask holds. The status bit positions are arbitration lost 0, no-acknowledge 1, access ready 2, receive ready 3, transmit ready 4, stop detected 5 and addressed as slave 6. The flag is visible from the clock edge that samples the pulse.
- R3: The mask register sits at byte offset 0x04. Its bits 0 to 6 are read/write, in the same positions as the status flags. Its upper bits always read 0.
- R4: `irq` is high exactly when some status flag in bits 0 to 6 is set and its mask bit is set.
- R5: The vector register sits at offset 0x28. It returns the bit index plus one (1 to 7) of the lowest-indexed flag that is both set and enabled, so arbitration lost has the highest priority. It returns 0 when no enabled flag is set, and a masked flag is never returned.
- R6: A read of the vector register that returns a nonzero code clears the flag it named at that clock edge. The next vector read returns the next pending source.
- R7: In the status register at offset 0x08, writing 1 to any of bits 0 to 6 clears that flag, and writing 0 leaves it unchanged. If a new event for the same flag arrives in the same cycle as the clear, the event wins and the flag stays set.
- R8: Status bit 12 is bus busy. A `bus_start` pulse sets it. A stop-detected pulse clears it, and `bus_start` wins when both come in the same cycle. Writes to the status register never change it.
- R9: Status bit 11 follows the `rx_full` input in the same cycle.
- R10: Writes to the vector register or to an unmapped offset change no state. Reads of an unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_arb_lost | input | 1 | Arbitration lost pulse |
| ev_nack | input | 1 | No-acknowledge pulse |
| ev_acc_rdy | input | 1 | Register-access ready pulse |
| ev_rx_rdy | input | 1 | Receive data ready pulse |
| ev_tx_rdy | input | 1 | Transmit data ready pulse |
| ev_stop_det | input | 1 | Stop condition detected pulse; also ends bus busy |
| ev_as_slave | input | 1 | Addressed-as-slave pulse |
| bus_start | input | 1 | START condition seen; sets bus busy |
| rx_full | input | 1 | Receive shift register full level |
| reg_addr | input | 6 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
An event pulse or a register write takes effect at the next rising edge, so the flags, `irq` and the vector code are due one edge after the stimulus. Read data and the live receive-full bit are due in the same cycle as the address. The bench drives every input on the falling edge and samples all outputs a fraction of a nanosecond later, in the same low phase. It then updates its own register model at the following rising edge. Each result is therefore compared in exactly the cycle the requirements name, and no check races an edge.

// File: rtl/i2c_event_vector.sv
module i2c_event_vector #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int N_SRC    = 7,
  parameter int OFS_MASK = 4,
  parameter int OFS_STAT = 8,
  parameter int OFS_VEC  = 40,
  parameter int RXF_BIT  = 11,
  parameter int BUSY_BIT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_arb_lost,
  input  logic              ev_nack,
  input  logic              ev_acc_rdy,
  input  logic              ev_rx_rdy,
  input  logic              ev_tx_rdy,
  input  logic              ev_stop_det,
  input  logic              ev_as_slave,
  input  logic              bus_start,
  input  logic              rx_full,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int CODE_W = $clog2(N_SRC + 1);

  logic [N_SRC-1:0]  ev_vec, flag_q, mask_q, pend, clr;
  logic [CODE_W-1:0] vec_code;
  logic              busy_q;
  logic              sel_mask, sel_stat, sel_vec;
  logic              wr_stat, rd_vec;
  logic [DATA_W-1:0] stat_word;
  logic              unused_wbits;

  assign ev_vec = {ev_as_slave, ev_stop_det, ev_tx_rdy, ev_rx_rdy,
                   ev_acc_rdy, ev_nack, ev_arb_lost};

  assign sel_mask = reg_addr == ADDR_W'(OFS_MASK);
  assign sel_stat = reg_addr == ADDR_W'(OFS_STAT);
  assign sel_vec  = reg_addr == ADDR_W'(OFS_VEC);
  assign wr_stat  = reg_wr && sel_stat;
  assign rd_vec   = reg_rd && sel_vec;
  assign unused_wbits = ^reg_wdata[DATA_W-1:N_SRC];

  assign pend = flag_q & mask_q;
  assign irq  = |pend;

  always_comb begin
    vec_code = '0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (pend[i]) vec_code = CODE_W'(i + 1);
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign clr[g] = (wr_stat && reg_wdata[g]) ||
                    (rd_vec && vec_code == CODE_W'(g + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flag_q[g] <= 1'b0;
      else if (ev_vec[g]) flag_q[g] <= 1'b1;
      else if (clr[g])    flag_q[g] <= 1'b0;
    end

    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      ev_vec[g] |=> flag_q[g]);

    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_vec && vec_code == CODE_W'(g + 1) && !ev_vec[g]) |=> !flag_q[g]);

    a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && reg_wdata[g] && !ev_vec[g]) |=> !flag_q[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  mask_q <= '0;
    else if (reg_wr && sel_mask) mask_q <= reg_wdata[N_SRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           busy_q <= 1'b0;
    else if (bus_start)   busy_q <= 1'b1;
    else if (ev_stop_det) busy_q <= 1'b0;
  end

  always_comb begin
    stat_word               = '0;
    stat_word[N_SRC-1:0]    = flag_q;
    stat_word[RXF_BIT]      = rx_full;
    stat_word[BUSY_BIT]     = busy_q;
  end

  always_comb begin
    reg_rdata = '0;
    if (sel_mask)     reg_rdata = DATA_W'(mask_q);
    else if (sel_stat) reg_rdata = stat_word;
    else if (sel_vec)  reg_rdata = DATA_W'(vec_code);
  end

  a_r4_irq_vs_vector: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (vec_code != '0));

  a_r8_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> busy_q);

  a_r8_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop_det && !bus_start) |=> !busy_q);

  a_r8_busy_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !bus_start && !ev_stop_det) |=> $stable(busy_q));

  a_r10_vec_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && sel_vec && ev_vec == '0) |=> $stable(flag_q) && $stable(mask_q));
endmodule

// File: tb/sim_i2c_event_vector.sv
`timescale 1ns/1ps
module sim_i2c_event_vector;
  localparam logic [5:0] A_MASK = 6'h04, A_STAT = 6'h08, A_VEC = 6'h28, A_NONE = 6'h10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [6:0] ev = '0;
  logic bus_start = 1'b0, rx_full = 1'b0;
  logic [5:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic irq;

  int total = 0, bad = 0;
  bit done = 1'b0;

  logic [6:0] m_flag = '0, m_mask = '0;
  logic m_busy = 1'b0;

  always #2 clk = ~clk;

  i2c_event_vector u0 (
    .clk(clk), .rst_n(rst_n),
    .ev_arb_lost(ev[0]), .ev_nack(ev[1]), .ev_acc_rdy(ev[2]), .ev_rx_rdy(ev[3]),
    .ev_tx_rdy(ev[4]), .ev_stop_det(ev[5]), .ev_as_slave(ev[6]),
    .bus_start(bus_start), .rx_full(rx_full),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [2:0] m_code();
    for (int i = 0; i < 7; i++)
      if (m_flag[i] && m_mask[i]) return 3'(i + 1);
    return 3'd0;
  endfunction

  function automatic logic [15:0] m_read(logic [5:0] a);
    logic [15:0] s;
    s = '0;
    s[6:0] = m_flag;
    s[11] = rx_full;
    s[12] = m_busy;
    case (a)
      A_MASK:  return {9'd0, m_mask};
      A_STAT:  return s;
      A_VEC:   return {13'd0, m_code()};
      default: return 16'd0;
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(logic [6:0] e, bit st, bit wr, bit rd, logic [5:0] a,
                      logic [15:0] d, bit rxf, string tag);
    logic [6:0] clr;
    logic [2:0] code;
    @(negedge clk);
    ev = e; bus_start = st; reg_wr = wr; reg_rd = rd;
    reg_addr = a; reg_wdata = d; rx_full = rxf;
    #0.5;
    check({tag, " R4 irq"}, {15'd0, irq}, {15'd0, |(m_flag & m_mask)});
    if (rd) check({tag, " read"}, reg_rdata, m_read(a));
    code = m_code();
    clr = '0;
    if (wr && a == A_STAT) clr = d[6:0];
    if (rd && a == A_VEC && code != 0) clr[code - 1] = 1'b1;
    @(posedge clk);
    m_flag = (m_flag & ~clr) | e;
    if (wr && a == A_MASK) m_mask = d[6:0];
    if (st) m_busy = 1'b1;
    else if (e[5]) m_busy = 1'b0;
  endtask

  task automatic idle();
    tick('0, 0, 0, 0, A_NONE, '0, rx_full, "idle");
  endtask

  task automatic rd_exp(logic [5:0] a, logic [15:0] exp, string tag);
    @(negedge clk);
    ev = '0; bus_start = 0; reg_wr = 0; reg_rd = 0; reg_addr = a;
    #0.5;
    check(tag, reg_rdata, exp);
    tick('0, 0, 0, 1, a, '0, rx_full, tag);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1c2a));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #0.5;
    check("R1 irq reset", {15'd0, irq}, 16'd0);
    rd_exp(A_MASK, 16'h0000, "R1 mask reset");
    rd_exp(A_STAT, 16'h0000, "R1 status reset");
    rd_exp(A_VEC, 16'h0000, "R1 vector reset");

    for (int i = 0; i < 7; i++) tick(7'(1 << i), 0, 0, 0, A_NONE, '0, 0, "R2 pulse");
    rd_exp(A_STAT, 16'h007F, "R2 all flags set masked");
    check("R4 masked no irq", {15'd0, irq}, 16'd0);
    rd_exp(A_VEC, 16'h0000, "R5 masked not returned");

    tick('0, 0, 1, 0, A_MASK, 16'hFFFF, 0, "R3 write");
    rd_exp(A_MASK, 16'h007F, "R3 upper bits zero");
    tick('0, 0, 1, 0, A_STAT, 16'h007F, 0, "R7 clear all");
    rd_exp(A_STAT, 16'h0000, "R7 all cleared");

    tick(7'b0100010, 0, 0, 0, A_NONE, '0, 0, "R5 nack+stop");
    rd_exp(A_VEC, 16'd2, "R5 nack first");
    rd_exp(A_VEC, 16'd6, "R6 next is stop");
    rd_exp(A_VEC, 16'd0, "R6 drained");
    idle();
    check("R4 irq low after drain", {15'd0, irq}, 16'd0);

    tick('0, 0, 1, 0, A_MASK, 16'h0020, 0, "R5 mask only stop");
    tick(7'b0100001, 0, 0, 0, A_NONE, '0, 0, "R5 al+stop");
    idle();
    check("R4 irq high", {15'd0, irq}, 16'd1);
    rd_exp(A_VEC, 16'd6, "R5 masked AL skipped");
    rd_exp(A_STAT, 16'h0001, "R6 AL still pending");

    tick(7'b0000100, 0, 0, 0, A_NONE, '0, 0, "R7 ardy");
    tick(7'b0000100, 0, 1, 0, A_STAT, 16'h0004, 0, "R7 event beats clear");
    rd_exp(A_STAT, 16'h0005, "R7 ardy kept");
    tick('0, 0, 1, 0, A_STAT, 16'h0004, 0, "R7 clear ardy");
    rd_exp(A_STAT, 16'h0001, "R7 zero bits keep AL");

    tick('0, 1, 0, 0, A_NONE, '0, 0, "R8 start");
    tick('0, 0, 1, 0, A_STAT, 16'hFFFF, 0, "R8 write all");
    rd_exp(A_STAT, 16'h1000, "R8 busy survives write");
    tick(7'b0100000, 1, 0, 0, A_NONE, '0, 0, "R8 start+stop");
    rd_exp(A_STAT, 16'h1020, "R8 start wins");
    tick(7'b0100000, 0, 0, 0, A_NONE, '0, 0, "R8 stop");
    rd_exp(A_STAT, 16'h0020, "R8 busy cleared");

    rx_full = 1'b1;
    rd_exp(A_STAT, 16'h0820, "R9 rx full live");
    rx_full = 1'b0;
    rd_exp(A_STAT, 16'h0020, "R9 rx full drop");

    tick('0, 0, 1, 0, A_VEC, 16'hFFFF, 0, "R10 write vector");
    tick('0, 0, 1, 0, A_NONE, 16'hFFFF, 0, "R10 write unmapped");
    rd_exp(A_MASK, 16'h0020, "R10 mask untouched");
    rd_exp(A_STAT, 16'h0020, "R10 status untouched");
    rd_exp(A_NONE, 16'h0000, "R10 unmapped reads 0");

    for (int n = 0; n < 4000; n++) begin
      logic [6:0] e;
      logic [5:0] a;
      int op;
      e = ($urandom % 4 == 0) ? 7'($urandom) & 7'($urandom) : 7'd0;
      op = $urandom % 6;
      case ($urandom % 5)
        0: a = A_MASK; 1, 2: a = A_STAT; 3: a = A_VEC; default: a = A_NONE;
      endcase
      tick(e, ($urandom % 8) == 0, op == 0, op == 1 || op == 2, a,
           16'($urandom), ($urandom % 2) == 1, "R5 R6 R7 random");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule